// File: doc/BRIEF.md
# USB Receive Endpoint Status and Control Byte

This block holds the control and status byte of one USB device receive (host-to-device) endpoint. It also tracks how many packets sit in that endpoint's receive FIFO, which holds either one packet or, with double buffering on, two. The packet engine reports four events:

- a packet was taken in
- that packet had a CRC or bit-stuffing fault
- a STALL handshake went out
- a packet arrived while the FIFO was full

Firmware reads the byte, writes commands into it, and clears the flags the hardware sets. On the FIFO side the block asks for a read-pointer reset and for the release of the head packet. Its other outputs are a STALL request, the current data toggle, a FIFO-full flag and a one-cycle interrupt pulse.

A four-state machine handles the head of the FIFO:

- EMPTY: no packet is presented.
- READY: the head packet is offered to firmware and the ready flag reads 1.
- FLUSH: one cycle in which the head packet is discarded and the FIFO read pointer is reset.
- DRAIN: one cycle in which the head packet is released after firmware has cleared the ready flag.

The transitions are:

- EMPTY to READY when a packet is accepted.
- READY to FLUSH on a flush command.
- READY to DRAIN when firmware writes 0 to the ready flag.
- FLUSH or DRAIN to READY when another packet remains, which raises a new interrupt.
- FLUSH or DRAIN to EMPTY when none remains.

Flags that the hardware sets are cleared by writing 0 to them. A write that should leave such a flag alone must therefore carry a 1 in its position.

Top module: `usb_out_ep_csr`

## Requirements
- R1: After reset `reg_rdata` reads 0x00 and `stall_req`, `data_toggle`, `fifo_full`, `irq`, `fifo_ptr_rst` and `fifo_pkt_release` are all 0.
- R2: Bit 7 is the toggle-reset command. Writing 1 there forces `data_toggle` to 0, and bit 7 always reads 0. Outside isochronous mode every accepted packet inverts `data_toggle`. In isochronous mode the toggle holds.
- R3: Bit 6 (stall-sent) becomes 1 the cycle after `ev_stall_sent`. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R4: Bit 5 (stall-request) is a plain read/write bit. `stall_req` equals bit 5 while `iso_mode` is 0 and is 0 while `iso_mode` is 1.
- R5: Bit 0 (packet-ready) becomes 1 the cycle after a packet is accepted into an empty FIFO. `irq` pulses high for exactly that one cycle.
- R6: A write with bit 0 = 0 and bit 4 = 0 while packet-ready is 1 has the following effect:
  - bit 0 reads 0 the next cycle, and `fifo_pkt_release` is 1 for that one cycle;
  - the packet count then drops by one;
  - if a packet remains, bit 0 and `irq` return the cycle after.
- R7: A write with bit 4 = 1 while packet-ready is 1 starts a flush:
  - for one cycle bit 4 reads 1, bit 0 reads 0, and `fifo_ptr_rst` and `fifo_pkt_release` are 1;
  - the count then drops and a remaining packet is offered again as in R6;
  - a flush written while no packet is held changes nothing and bit 4 reads 0.
- R8: Bit 3 (data-error) is set only in isochronous mode, when an accepted packet carries `ev_pkt_bad`. It clears when firmware clears packet-ready as in R6.
- R9: Bit 2 (overrun) is set only in isochronous mode, by `ev_overrun`. Writing 0 clears it.
- R10: Bit 1 and `fifo_full` read 1 when two packets are held with `dbl_buf_en` = 1, or one packet with `dbl_buf_en` = 0. A packet reported while the FIFO is full is not counted and does not change the toggle.
- R11: Writes to bits 3 and 1 have no effect. Writing 1 to bit 0 when packet-ready is 0 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iso_mode | input | 1 | Endpoint runs isochronous transfers |
| dbl_buf_en | input | 1 | FIFO holds up to two packets |
| reg_wr | input | 1 | Firmware write strobe |
| reg_wdata | input | 8 | Firmware write data |
| reg_rdata | output | 8 | Current register byte |
| ev_pkt_rx | input | 1 | Packet engine delivered a packet |
| ev_pkt_bad | input | 1 | Delivered packet had a CRC or stuffing fault |
| ev_stall_sent | input | 1 | STALL handshake was transmitted |
| ev_overrun | input | 1 | A packet was lost to a full FIFO |
| fifo_ptr_rst | output | 1 | Reset FIFO read pointer |
| fifo_pkt_release | output | 1 | Drop the head packet from the FIFO |
| stall_req | output | 1 | Answer tokens with STALL |
| data_toggle | output | 1 | Expected data toggle |
| fifo_full | output | 1 | FIFO cannot take another packet |
| irq | output | 1 | One-cycle packet-ready interrupt |

## Verification
The hardest case to reach is the return from DRAIN or FLUSH to READY with a fresh interrupt. That path needs two packets queued with double buffering enabled, with the FIFO-full flag visible, before firmware acts. The stimulus table therefore delivers two packets back to back and then a third into the full FIFO to show that it is dropped. It next clears the ready flag, which lets the second packet resurface, and then flushes that packet. After the table, directed steps revisit the single-buffer full case, a flush on an empty FIFO, and the isochronous-only flags with isochronous mode switched off.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_READY = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DRAIN = 2'd3
    } ep_state_e;

    localparam int BIT_CLRTOG  = 7;
    localparam int BIT_STLSENT = 6;
    localparam int BIT_STLREQ  = 5;
    localparam int BIT_FLUSH   = 4;
    localparam int BIT_DATERR  = 3;
    localparam int BIT_OVRUN   = 2;
    localparam int BIT_FULL    = 1;
    localparam int BIT_RDY     = 0;
endpackage

// File: rtl/usb_out_ep_pkt_fsm.sv
module usb_out_ep_pkt_fsm
    import usb_out_ep_pkg::*;
#(
    parameter int MAX_PKTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dbl_buf_en,
    input  logic pkt_rx,
    input  logic sw_wr,
    input  logic sw_rdy_bit,
    input  logic sw_flush_bit,
    output logic accept,
    output logic rdy_cleared,
    output logic rdy,
    output logic flushing,
    output logic full,
    output logic ptr_rst,
    output logic pkt_release,
    output logic irq
);
    localparam int CNT_W = $clog2(MAX_PKTS + 1);

    ep_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             irq_q;
    logic             done;

    // Full threshold depends on the buffering mode.
    assign full   = dbl_buf_en ? (cnt_q == CNT_W'(MAX_PKTS)) : (cnt_q != '0);
    assign accept = pkt_rx && !full;
    assign done   = (state_q == ST_FLUSH) || (state_q == ST_DRAIN);
    assign cnt_d  = cnt_q + CNT_W'(accept) - CNT_W'(done);

    assign rdy_cleared = (state_q == ST_READY) && sw_wr && !sw_flush_bit && !sw_rdy_bit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_READY;
            ST_READY: begin
                if (sw_wr && sw_flush_bit)   state_d = ST_FLUSH;
                else if (rdy_cleared)        state_d = ST_DRAIN;
            end
            ST_FLUSH, ST_DRAIN: state_d = (cnt_d != '0) ? ST_READY : ST_EMPTY;
            default: state_d = ST_EMPTY;
        endcase
    end

    // State and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            irq_q   <= (state_d == ST_READY) && (state_q != ST_READY);
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rdy         = (state_q == ST_READY);
        flushing    = (state_q == ST_FLUSH);
        ptr_rst     = (state_q == ST_FLUSH);
        pkt_release = done;
        irq         = irq_q;
    end
endmodule

// File: rtl/usb_out_ep_flags.sv
module usb_out_ep_flags
    import usb_out_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic iso_mode,
    input  logic sw_wr,
    input  logic sw_clrtog,
    input  logic sw_stlsent,
    input  logic sw_stlreq,
    input  logic sw_ovrun,
    input  logic stall_sent,
    input  logic overrun_ev,
    input  logic pkt_bad,
    input  logic accept,
    input  logic rdy_cleared,
    output logic stlsent,
    output logic stlreq,
    output logic daterr,
    output logic ovrun,
    output logic toggle
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stlsent <= 1'b0;
            stlreq  <= 1'b0;
            daterr  <= 1'b0;
            ovrun   <= 1'b0;
            toggle  <= 1'b0;
        end else begin
            if (stall_sent)                  stlsent <= 1'b1;
            else if (sw_wr && !sw_stlsent)   stlsent <= 1'b0;

            if (sw_wr) stlreq <= sw_stlreq;

            if (iso_mode && accept && pkt_bad) daterr <= 1'b1;
            else if (rdy_cleared)              daterr <= 1'b0;

            if (iso_mode && overrun_ev)      ovrun <= 1'b1;
            else if (sw_wr && !sw_ovrun)     ovrun <= 1'b0;

            if (sw_wr && sw_clrtog)          toggle <= 1'b0;
            else if (accept && !iso_mode)    toggle <= !toggle;
        end
    end
endmodule

// File: rtl/usb_out_ep_csr.sv
module usb_out_ep_csr
    import usb_out_ep_pkg::*;
#(
    parameter int MAX_PKTS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iso_mode,
    input  logic       dbl_buf_en,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ev_pkt_rx,
    input  logic       ev_pkt_bad,
    input  logic       ev_stall_sent,
    input  logic       ev_overrun,
    output logic       fifo_ptr_rst,
    output logic       fifo_pkt_release,
    output logic       stall_req,
    output logic       data_toggle,
    output logic       fifo_full,
    output logic       irq
);
    logic accept, rdy_cleared, rdy, flushing;
    logic stlsent, stlreq, daterr, ovrun;

    usb_out_ep_pkt_fsm #(.MAX_PKTS(MAX_PKTS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbl_buf_en   (dbl_buf_en),
        .pkt_rx       (ev_pkt_rx),
        .sw_wr        (reg_wr),
        .sw_rdy_bit   (reg_wdata[BIT_RDY]),
        .sw_flush_bit (reg_wdata[BIT_FLUSH]),
        .accept       (accept),
        .rdy_cleared  (rdy_cleared),
        .rdy          (rdy),
        .flushing     (flushing),
        .full         (fifo_full),
        .ptr_rst      (fifo_ptr_rst),
        .pkt_release  (fifo_pkt_release),
        .irq          (irq)
    );

    usb_out_ep_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .iso_mode    (iso_mode),
        .sw_wr       (reg_wr),
        .sw_clrtog   (reg_wdata[BIT_CLRTOG]),
        .sw_stlsent  (reg_wdata[BIT_STLSENT]),
        .sw_stlreq   (reg_wdata[BIT_STLREQ]),
        .sw_ovrun    (reg_wdata[BIT_OVRUN]),
        .stall_sent  (ev_stall_sent),
        .overrun_ev  (ev_overrun),
        .pkt_bad     (ev_pkt_bad),
        .accept      (accept),
        .rdy_cleared (rdy_cleared),
        .stlsent     (stlsent),
        .stlreq      (stlreq),
        .daterr      (daterr),
        .ovrun       (ovrun),
        .toggle      (data_toggle)
    );

    assign stall_req = stlreq && !iso_mode;

    always_comb begin
        reg_rdata              = '0;
        reg_rdata[BIT_STLSENT] = stlsent;
        reg_rdata[BIT_STLREQ]  = stlreq;
        reg_rdata[BIT_FLUSH]   = flushing;
        reg_rdata[BIT_DATERR]  = daterr;
        reg_rdata[BIT_OVRUN]   = ovrun;
        reg_rdata[BIT_FULL]    = fifo_full;
        reg_rdata[BIT_RDY]     = rdy;
    end
endmodule

// File: rtl/usb_out_ep_csr_chk.sv
module usb_out_ep_csr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       iso_mode,
    input logic       ev_stall_sent,
    input logic       ev_overrun,
    input logic [7:0] reg_rdata,
    input logic       fifo_ptr_rst,
    input logic       fifo_pkt_release,
    input logic       stall_req,
    input logic       irq
);
    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_irq_with_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reg_rdata[0]);
    assert_release_hides_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pkt_release |-> !reg_rdata[0]);
    assert_flush_bundle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ptr_rst |-> (fifo_pkt_release && reg_rdata[4]));
    assert_flush_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] |=> !reg_rdata[4]);
    assert_stall_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> !iso_mode);
    assert_clrtog_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[7]);
    assert_stlsent_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[6]) |-> $past(ev_stall_sent));
    assert_ovrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[2]) |-> $past(ev_overrun && iso_mode));
endmodule

bind usb_out_ep_csr usb_out_ep_csr_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .iso_mode         (iso_mode),
    .ev_stall_sent    (ev_stall_sent),
    .ev_overrun       (ev_overrun),
    .reg_rdata        (reg_rdata),
    .fifo_ptr_rst     (fifo_ptr_rst),
    .fifo_pkt_release (fifo_pkt_release),
    .stall_req        (stall_req),
    .irq              (irq)
);

// File: tb/usb_out_ep_csr_tb_top.sv
`timescale 1ns/1ps
module usb_out_ep_csr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iso_mode = 1'b0, dbl_buf_en = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ev_pkt_rx = 1'b0, ev_pkt_bad = 1'b0, ev_stall_sent = 1'b0, ev_overrun = 1'b0;
    logic       fifo_ptr_rst, fifo_pkt_release, stall_req, data_toggle, fifo_full, irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    usb_out_ep_csr dut_i (
        .clk(clk), .rst_n(rst_n), .iso_mode(iso_mode), .dbl_buf_en(dbl_buf_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_pkt_rx(ev_pkt_rx), .ev_pkt_bad(ev_pkt_bad), .ev_stall_sent(ev_stall_sent),
        .ev_overrun(ev_overrun), .fifo_ptr_rst(fifo_ptr_rst),
        .fifo_pkt_release(fifo_pkt_release), .stall_req(stall_req),
        .data_toggle(data_toggle), .fifo_full(fifo_full), .irq(irq)
    );

    // Vector: {wr, wdata[7:0], rx, bad, stall_ev, ovr_ev, iso, dbl, exp_rdata[7:0],
    //          exp {stall_req, toggle, full, irq, ptr_rst, release}}
    localparam int NV = 16;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 8'h00, 4'b1000, 2'b01, 8'h01, 6'b010100}, // R5 first packet, irq
        {1'b0, 8'h00, 4'b1000, 2'b01, 8'h03, 6'b001000}, // R10 second packet fills
        {1'b0, 8'h00, 4'b1000, 2'b01, 8'h03, 6'b001000}, // R10 packet into full dropped
        {1'b1, 8'h00, 4'b0000, 2'b01, 8'h02, 6'b001001}, // R6 clear ready -> drain
        {1'b0, 8'h00, 4'b0000, 2'b01, 8'h01, 6'b000100}, // R6 second packet resurfaces
        {1'b1, 8'h10, 4'b0000, 2'b01, 8'h10, 6'b000011}, // R7 flush cycle
        {1'b0, 8'h00, 4'b0000, 2'b01, 8'h00, 6'b000000}, // R7 empty after flush
        {1'b1, 8'h20, 4'b0000, 2'b01, 8'h20, 6'b100000}, // R4 stall request
        {1'b0, 8'h00, 4'b0010, 2'b01, 8'h60, 6'b100000}, // R3 stall sent flag
        {1'b1, 8'h20, 4'b0000, 2'b01, 8'h20, 6'b100000}, // R3 clear by writing 0
        {1'b0, 8'h00, 4'b0000, 2'b11, 8'h20, 6'b000000}, // R4 iso masks stall
        {1'b0, 8'h00, 4'b1100, 2'b11, 8'h29, 6'b000100}, // R8 bad iso packet
        {1'b0, 8'h00, 4'b0001, 2'b11, 8'h2D, 6'b000000}, // R9 overrun in iso
        {1'b1, 8'h24, 4'b0000, 2'b11, 8'h24, 6'b000001}, // R8 cleared with ready
        {1'b0, 8'h00, 4'b0000, 2'b11, 8'h24, 6'b000000}, // R9 overrun holds
        {1'b1, 8'h00, 4'b0000, 2'b11, 8'h00, 6'b000000}  // R9 overrun cleared
    };

    task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {stall_req, data_toggle, fifo_full, irq, fifo_ptr_rst, fifo_pkt_release};
    endfunction

    task automatic tick(input logic wr, input logic [7:0] wd, input logic rx,
                        input logic bad, input logic sts, input logic ovr);
        reg_wr = wr; reg_wdata = wd; ev_pkt_rx = rx; ev_pkt_bad = bad;
        ev_stall_sent = sts; ev_overrun = ovr;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00; ev_pkt_rx = 1'b0; ev_pkt_bad = 1'b0;
        ev_stall_sent = 1'b0; ev_overrun = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check8("R1 rdata", reg_rdata, 8'h00);
        check8("R1 outputs", {2'b00, outs()}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            iso_mode   = VEC[i][15];
            dbl_buf_en = VEC[i][14];
            tick(VEC[i][28], VEC[i][27:20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16]);
            check8($sformatf("vector %0d rdata", i), reg_rdata, VEC[i][13:6]);
            check8($sformatf("vector %0d outputs", i), {2'b00, outs()}, {2'b00, VEC[i][5:0]});
        end

        // R2 toggle reset command
        iso_mode = 1'b0; dbl_buf_en = 1'b1;
        tick(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        check8("R2 toggle flips", {7'd0, data_toggle}, 8'h01);
        tick(1'b1, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0);
        check8("R2 toggle cleared", {7'd0, data_toggle}, 8'h00);
        check8("R2 bit7 reads 0", reg_rdata, 8'h01);
        tick(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10 single buffering
        dbl_buf_en = 1'b0;
        tick(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        check8("R10 single full", reg_rdata, 8'h03);
        check8("R10 full port", {7'd0, fifo_full}, 8'h01);
        tick(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        check8("R10 dropped, toggle held", {6'd0, data_toggle, irq}, 8'h02);
        tick(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        check8("R6 single drain", reg_rdata, 8'h02);
        tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        check8("R6 no reload", {reg_rdata[7:1], irq}, 8'h00);

        // R7 flush on empty
        tick(1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0);
        check8("R7 empty flush", reg_rdata, 8'h00);
        check8("R7 empty flush fifo side", {6'd0, fifo_ptr_rst, fifo_pkt_release}, 8'h00);

        // R8/R9 outside iso
        dbl_buf_en = 1'b1;
        tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        check8("R9 no overrun outside iso", reg_rdata, 8'h00);
        tick(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        check8("R8 no data error outside iso", reg_rdata, 8'h01);
        tick(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

        // R11 / R3: writes of 1 to read-only or hardware-set bits
        tick(1'b1, 8'h4B, 1'b0, 1'b0, 1'b0, 1'b0);
        check8("R11 ignored writes", reg_rdata, 8'h00);
        check8("R11 no irq", {7'd0, irq}, 8'h00);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule